// File: doc/BRIEF.md
# Global 64-bit Counter with Comparator

This block is a memory-mapped system timer. A 64-bit free-running counter advances once per clock while its run bit is set, and software sees it as two live 32-bit halves. There is no snapshot register: to get a consistent value, software reads the upper half, then the lower half, then the upper half again, and retries if the two upper reads differ. The counter can be loaded one half at a time, normally while it is stopped.

One 64-bit compare channel watches the counter. When the comparator is enabled and the two values are equal, a sticky interrupt-status bit is set, and the interrupt line rises if the enable mask allows it. In one-shot mode the comparator keeps its value. In auto-increment mode each match adds a programmed 32-bit step to the comparator, so interrupts repeat with no software re-arming.

Every write to a timing register is confirmed by a sticky write-status bit, which software clears by writing one to it. Software uses these bits to learn when a write has been applied.

Top module: `gtimer_cmp`

## Requirements
- R1: While control bit 8 (run) is 1, the counter increases by exactly 1 each clock cycle, carrying from the lower into the upper half. While run is 0, the counter holds its value.
- R2: Offsets 0x100 (lower) and 0x104 (upper) read the live counter halves. A write to either offset replaces that half.
- R3: The control register at 0x240 holds bit 8 (run), bit 0 (comparator enable) and bit 1 (auto-increment). It reads back only those bits; every other bit reads 0.
- R4: The comparator lower word (0x200), comparator upper word (0x204) and 32-bit increment (0x208) read back the values written to them.
- R5: A match is an exact 64-bit equality between the counter and the comparator while the comparator is enabled. A match sets bit 0 of the interrupt status at 0x244 on the following edge, even when the interrupt is masked. Writing 1 to that bit clears it.
- R6: In auto-increment mode each match adds the increment to the comparator, so matches repeat every increment cycles. With auto-increment off, the comparator is unchanged by a match.
- R7: While the comparator enable is 0, no match occurs and the interrupt status stays clear.
- R8: The irq output is high exactly when interrupt status bit 0 and bit 0 of the enable register at 0x248 are both 1.
- R9: Writes to 0x200, 0x204, 0x208 and 0x240 set bits 0, 1, 2 and 16 of the write status at 0x24C. Each bit is set one cycle after the written value takes effect, stays set, and is cleared by writing 1 to it.
- R10: Writes to 0x100 and 0x104 set bits 0 and 1 of the counter write status at 0x110, with the same timing and the same write-one-to-clear rule as R9.
- R11: A read of an offset that maps to no register returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle in which it is high |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | Compare interrupt |

## Verification
The counter is checked from a preload of zero, and across the boundary where the lower half rolls over into the upper half. It is also checked stopped, which separates counting from holding. Compare events are tried in three set-ups:
- one-shot with the interrupt masked and then unmasked, which separates the status bit from the interrupt line;
- auto-increment, where the comparator must step forward by the increment and fire again with no new write;
- comparator disabled, where an equal value must not produce an event.

The one-shot run also samples the cycle just before and the cycle just after the match, which pins down when status is set. The write-status bits are sampled in the cycle the write lands and in the cycle after, and then cleared one bit at a time.

// File: rtl/gtm_pkg.sv
package gtm_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'h100;
  localparam logic [ADDR_W-1:0] A_CNT_HI  = 12'h104;
  localparam logic [ADDR_W-1:0] A_CNT_WST = 12'h110;
  localparam logic [ADDR_W-1:0] A_CMP_LO  = 12'h200;
  localparam logic [ADDR_W-1:0] A_CMP_HI  = 12'h204;
  localparam logic [ADDR_W-1:0] A_CMP_INC = 12'h208;
  localparam logic [ADDR_W-1:0] A_CTRL    = 12'h240;
  localparam logic [ADDR_W-1:0] A_IST     = 12'h244;
  localparam logic [ADDR_W-1:0] A_IEN     = 12'h248;
  localparam logic [ADDR_W-1:0] A_WST     = 12'h24C;

  // control register bit positions
  localparam int CTL_CEN  = 0;
  localparam int CTL_AUTO = 1;
  localparam int CTL_RUN  = 8;

  // write-status layout
  localparam int WST_W       = 17;
  localparam int WST_CMP_LO  = 0;
  localparam int WST_CMP_HI  = 1;
  localparam int WST_CMP_INC = 2;
  localparam int WST_CTRL    = 16;
  localparam int CWST_W      = 2;

  typedef struct packed {
    logic run;
    logic autoinc;
    logic cen;
  } ctrl_t;
endpackage

// File: rtl/gtm_counter.sv
module gtm_counter #(
  parameter int DATA_W = 32,
  localparam int CW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [DATA_W-1:0] wdata,
  output logic [CW-1:0]     cnt
);
  function automatic logic [CW-1:0] step_count(input logic [CW-1:0] c);
    return c + CW'(1);
  endfunction

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run ? step_count(cnt_q) : cnt_q;
    if (wr_lo) cnt_d[DATA_W-1:0]  = wdata;
    if (wr_hi) cnt_d[CW-1:DATA_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  assign cnt = cnt_q;
endmodule

// File: rtl/gtm_comparator.sv
module gtm_comparator #(
  parameter int DATA_W = 32,
  localparam int CW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cnt,
  input  logic              cen,
  input  logic              autoinc,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              wr_inc,
  input  logic [DATA_W-1:0] wdata,
  output logic [CW-1:0]     cmp,
  output logic [DATA_W-1:0] inc,
  output logic              match_evt,
  output logic              reload_evt
);
  function automatic logic [CW-1:0] reload_value(input logic [CW-1:0] c,
                                                 input logic [DATA_W-1:0] s);
    return c + CW'(s);
  endfunction

  logic [CW-1:0]     cmp_q, cmp_d;
  logic [DATA_W-1:0] inc_q;

  assign match_evt  = cen && (cnt == cmp_q);
  assign reload_evt = match_evt && autoinc;

  always_comb begin
    cmp_d = reload_evt ? reload_value(cmp_q, inc_q) : cmp_q;
    if (wr_lo) cmp_d[DATA_W-1:0]  = wdata;
    if (wr_hi) cmp_d[CW-1:DATA_W] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmp_q <= '0;
      inc_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      if (wr_inc) inc_q <= wdata;
    end

  assign cmp = cmp_q;
  assign inc = inc_q;
endmodule

// File: rtl/gtm_sticky.sv
module gtm_sticky #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_stb,
  input  logic         clr_stb,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] st
);
  logic [N-1:0] pend_q, st_q;

  // set one cycle after the write lands; a pending set wins over a clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= '0;
      st_q   <= '0;
    end else begin
      pend_q <= set_stb;
      st_q   <= (st_q & ~(clr_stb ? clr_mask : '0)) | pend_q;
    end

  assign st = st_q;
endmodule

// File: rtl/gtimer_cmp.sv
module gtimer_cmp
  import gtm_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CW = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  // decoded write strobes
  logic cnt_lo_wr, cnt_hi_wr, cmp_lo_wr, cmp_hi_wr, inc_wr, ctrl_wr;
  logic ist_wr, ien_wr, wst_wr, cwst_wr, cnt_wr, cmp_wr;

  assign cnt_lo_wr = bus_we && (bus_addr == A_CNT_LO);
  assign cnt_hi_wr = bus_we && (bus_addr == A_CNT_HI);
  assign cmp_lo_wr = bus_we && (bus_addr == A_CMP_LO);
  assign cmp_hi_wr = bus_we && (bus_addr == A_CMP_HI);
  assign inc_wr    = bus_we && (bus_addr == A_CMP_INC);
  assign ctrl_wr   = bus_we && (bus_addr == A_CTRL);
  assign ist_wr    = bus_we && (bus_addr == A_IST);
  assign ien_wr    = bus_we && (bus_addr == A_IEN);
  assign wst_wr    = bus_we && (bus_addr == A_WST);
  assign cwst_wr   = bus_we && (bus_addr == A_CNT_WST);
  assign cnt_wr    = cnt_lo_wr || cnt_hi_wr;
  assign cmp_wr    = cmp_lo_wr || cmp_hi_wr;

  // control, interrupt status and mask
  ctrl_t ctrl_q;
  logic  ist_q, ien_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q <= '0;
      ien_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.run     <= bus_wdata[CTL_RUN];
        ctrl_q.autoinc <= bus_wdata[CTL_AUTO];
        ctrl_q.cen     <= bus_wdata[CTL_CEN];
      end
      if (ien_wr) ien_q <= bus_wdata[0];
    end

  // counter and comparator
  logic [CW-1:0]     cnt, cmp;
  logic [DATA_W-1:0] inc;
  logic              match_evt, reload_evt;

  gtm_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(ctrl_q.run),
    .wr_lo(cnt_lo_wr), .wr_hi(cnt_hi_wr), .wdata(bus_wdata), .cnt(cnt)
  );

  gtm_comparator #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cen(ctrl_q.cen),
    .autoinc(ctrl_q.autoinc), .wr_lo(cmp_lo_wr), .wr_hi(cmp_hi_wr),
    .wr_inc(inc_wr), .wdata(bus_wdata), .cmp(cmp), .inc(inc),
    .match_evt(match_evt), .reload_evt(reload_evt)
  );

  // match status: set wins over a simultaneous clear
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ist_q <= 1'b0;
    else        ist_q <= (ist_q && !(ist_wr && bus_wdata[0])) || match_evt;

  assign irq = ist_q && ien_q;

  // write-status registers
  logic [WST_W-1:0]  wst_set, wst;
  logic [CWST_W-1:0] cwst;

  always_comb begin
    wst_set              = '0;
    wst_set[WST_CMP_LO]  = cmp_lo_wr;
    wst_set[WST_CMP_HI]  = cmp_hi_wr;
    wst_set[WST_CMP_INC] = inc_wr;
    wst_set[WST_CTRL]    = ctrl_wr;
  end

  gtm_sticky #(.N(WST_W)) u_wst (
    .clk(clk), .rst_n(rst_n), .set_stb(wst_set), .clr_stb(wst_wr),
    .clr_mask(bus_wdata[WST_W-1:0]), .st(wst)
  );

  gtm_sticky #(.N(CWST_W)) u_cwst (
    .clk(clk), .rst_n(rst_n), .set_stb({cnt_hi_wr, cnt_lo_wr}),
    .clr_stb(cwst_wr), .clr_mask(bus_wdata[CWST_W-1:0]), .st(cwst)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CNT_LO:  bus_rdata = cnt[DATA_W-1:0];
      A_CNT_HI:  bus_rdata = cnt[CW-1:DATA_W];
      A_CNT_WST: bus_rdata = DATA_W'(cwst);
      A_CMP_LO:  bus_rdata = cmp[DATA_W-1:0];
      A_CMP_HI:  bus_rdata = cmp[CW-1:DATA_W];
      A_CMP_INC: bus_rdata = inc;
      A_CTRL: begin
        bus_rdata[CTL_RUN]  = ctrl_q.run;
        bus_rdata[CTL_AUTO] = ctrl_q.autoinc;
        bus_rdata[CTL_CEN]  = ctrl_q.cen;
      end
      A_IST:     bus_rdata = DATA_W'(ist_q);
      A_IEN:     bus_rdata = DATA_W'(ien_q);
      A_WST:     bus_rdata = DATA_W'(wst);
      default:   bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gtm_checker.sv
module gtm_checker #(
  parameter int DATA_W = 32,
  localparam int CW = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              cen,
  input logic              autoinc,
  input logic [CW-1:0]     cnt,
  input logic [CW-1:0]     cmp,
  input logic [DATA_W-1:0] inc,
  input logic              match_evt,
  input logic              cnt_wr,
  input logic              cnt_lo_wr,
  input logic              cmp_wr,
  input logic              cmp_lo_wr,
  input logic              inc_wr,
  input logic              ist,
  input logic              ien,
  input logic              irq,
  input logic [16:0]       wst,
  input logic [1:0]        cwst
);
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !cnt_wr) |=> (cnt == $past(cnt) + CW'(1)));

  p_cnt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> $stable(cnt));

  p_match_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    match_evt |=> ist);

  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && autoinc && !cmp_wr) |=> (cmp == $past(cmp) + CW'($past(inc))));

  p_oneshot_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !autoinc && !cmp_wr) |=> $stable(cmp));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen && !ist) |=> !ist);

  p_irq_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien || !ist) |-> !irq);

  p_inc_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_wr |=> $stable(inc));

  p_wst_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_lo_wr |=> ##1 wst[0]);

  p_cwst_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_lo_wr |=> ##1 cwst[0]);
endmodule

bind gtimer_cmp gtm_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl_q.run), .cen(ctrl_q.cen),
  .autoinc(ctrl_q.autoinc), .cnt(cnt), .cmp(cmp), .inc(inc),
  .match_evt(match_evt), .cnt_wr(cnt_wr), .cnt_lo_wr(cnt_lo_wr),
  .cmp_wr(cmp_wr), .cmp_lo_wr(cmp_lo_wr), .inc_wr(inc_wr), .ist(ist_q),
  .ien(ien_q), .irq(irq), .wst(wst), .cwst(cwst)
);

// File: tb/sim_gtimer_cmp.sv
`timescale 1ns/1ps
module sim_gtimer_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  gtimer_cmp u0 (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
                 .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  // one write: strobe applied at the next rising edge, returns at the negedge after it
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_now(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_now(a, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(12'h100, v); chk("R1 reset counter lo", v, 0);
    rd(12'h240, v); chk("R3 reset control", v, 0);
    chk("R8 reset irq", {31'b0, irq}, 0);
    rd(12'h300, v); chk("R11 unmapped read", v, 0);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] v;
    wr(12'h240, 32'hFFFF_FFFF);
    rd(12'h240, v); chk("R3 control readback", v, 32'h0000_0103);
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    wr(12'h24C, 32'hFFFF_FFFF);
    rd(12'h244, v); chk("R5 status cleared by w1c", v, 0);
  endtask

  task automatic t_wstat;
    logic [31:0] v;
    wr(12'h200, 32'd7);
    rd_now(12'h24C, v); chk("R9 wstat not yet set", v, 0);
    rd(12'h24C, v);     chk("R9 wstat bit0 set", v, 32'h1);
    wr(12'h204, 32'd0);
    wr(12'h208, 32'd30);
    wr(12'h240, 32'd0);
    rd(12'h24C, v);     chk("R9 wstat all four", v, 32'h0001_0007);
    repeat (3) @(negedge clk);
    rd(12'h24C, v);     chk("R9 wstat sticky", v, 32'h0001_0007);
    wr(12'h24C, 32'h2);
    rd(12'h24C, v);     chk("R9 wstat w1c one bit", v, 32'h0001_0005);
    rd(12'h208, v);     chk("R4 increment readback", v, 30);
    rd(12'h200, v);     chk("R4 compare lo readback", v, 7);
    wr(12'h100, 32'd0);
    rd_now(12'h110, v); chk("R10 cwst not yet set", v, 0);
    rd(12'h110, v);     chk("R10 cwst bit0", v, 32'h1);
    wr(12'h104, 32'd0);
    rd(12'h110, v);     chk("R10 cwst both", v, 32'h3);
    wr(12'h110, 32'h3);
    rd(12'h110, v);     chk("R10 cwst cleared", v, 0);
  endtask

  task automatic t_carry;
    logic [31:0] v, w;
    wr(12'h240, 32'h0);
    wr(12'h100, 32'hFFFF_FFFE);
    wr(12'h104, 32'd5);
    rd(12'h104, v); chk("R2 preload hi", v, 5);
    rd(12'h100, v); chk("R2 preload lo", v, 32'hFFFF_FFFE);
    wr(12'h240, 32'h100);
    repeat (5) @(negedge clk);
    rd(12'h104, v); chk("R1 carry into upper half", v, 6);
    rd(12'h100, v);
    repeat (10) @(negedge clk);
    rd(12'h100, w); chk("R1 steps of one", w - v, 11);
    wr(12'h240, 32'h0);
    rd(12'h100, v);
    repeat (5) @(negedge clk);
    rd(12'h100, w); chk("R1 hold while stopped", w, v);
  endtask

  // one-shot match at count 50 with interrupt masked, then unmasked
  task automatic t_oneshot;
    logic [31:0] v;
    wr(12'h240, 32'h0);
    wr(12'h248, 32'h0);
    wr(12'h100, 32'd0); wr(12'h104, 32'd0);
    wr(12'h200, 32'd50); wr(12'h204, 32'd0);
    wr(12'h244, 32'h1);
    wr(12'h240, 32'h101);            // run + enable, one-shot
    repeat (48) @(negedge clk);
    rd(12'h244, v); chk("R5 no status before match", v, 0);
    rd(12'h100, v); chk("R1 count at match cycle", v, 50);
    rd(12'h244, v); chk("R5 status after match (masked)", v, 1);
    chk("R8 irq low while masked", {31'b0, irq}, 0);
    wr(12'h248, 32'h1);
    chk("R8 irq high when unmasked", {31'b0, irq}, 1);
    rd(12'h200, v); chk("R6 one-shot compare unchanged", v, 50);
    wr(12'h244, 32'h1);
    repeat (20) @(negedge clk);
    rd(12'h244, v); chk("R5 status stays clear after w1c", v, 0);
    chk("R8 irq low after clear", {31'b0, irq}, 0);
  endtask

  task automatic t_auto;
    logic [31:0] v;
    wr(12'h240, 32'h0);
    wr(12'h100, 32'd0); wr(12'h104, 32'd0);
    wr(12'h200, 32'd20); wr(12'h204, 32'd0);
    wr(12'h208, 32'd30);
    wr(12'h244, 32'h1);
    wr(12'h240, 32'h103);            // run + enable + auto
    repeat (90) @(negedge clk);
    rd(12'h200, v); chk("R6 compare advanced by increment", v, 110);
    wr(12'h244, 32'h1);
    rd(12'h244, v); chk("R6 status cleared mid-period", v, 0);
    repeat (35) @(negedge clk);
    rd(12'h244, v); chk("R6 periodic re-fire", v, 1);
    rd(12'h200, v); chk("R6 compare advanced again", v, 140);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    wr(12'h240, 32'h0);
    wr(12'h244, 32'h1);
    wr(12'h100, 32'd0); wr(12'h104, 32'd0);
    wr(12'h200, 32'd10); wr(12'h204, 32'd0);
    wr(12'h240, 32'h100);            // run only
    repeat (30) @(negedge clk);
    rd(12'h244, v); chk("R7 no match while disabled", v, 0);
    chk("R7 irq low while disabled", {31'b0, irq}, 0);
    wr(12'h240, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl_bits;
    t_wstat;
    t_carry;
    t_oneshot;
    t_auto;
    t_disabled;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule